// File: doc/BRIEF.md
# Serial Addressed Wiper Register Bank

This block holds the 8-bit settings of up to four potentiometer-style channels and loads them from a three-wire synchronous serial port. The port has a serial clock, a data line and an active-low chip select. While chip select is low, each rising serial clock edge shifts one bit into a 10-bit frame register. A frame carries a 2-bit channel address followed by an 8-bit code, each field most significant bit first. When chip select returns high, the code is written into the addressed channel. The parallel codes of all channels are presented as outputs.

The serial pins are asynchronous to the system clock. They are brought into the system clock domain by a two-stage synchronizer, and their edges are detected there, so every register runs on one clock. A serial data output presents the bit that has passed through the whole frame register. It changes after each falling serial clock edge, so several devices can be cascaded on one chip select, with each device's output feeding the next device's input. An active-low reset puts every channel at midscale.

Top module: `serpot_bank`

## Requirements
- R1: While `rst_n` is low, every channel code is 0x80, `ser_dout` is 0 and `upd_stb` is 0.
- R2: A frame is sent first bit first as address bit 1, address bit 0, then data bits 7 down to 0. After 10 serial clocks and a rising chip select, the channel with index {A1,A0} holds the data byte.
- R3: Serial clock edges that occur while chip select is high shift nothing into the frame register.
- R4: Channel codes change only on the load that follows a rising chip select. Shifting, a falling chip select and serial clock edges leave them unchanged.
- R5: A load changes only the addressed channel. The other channels keep their codes.
- R6: If chip select rises after a number of serial clocks other than 10, the load uses the last 10 bits received. The frame register is not cleared between frames, so bits from earlier frames fill any shortfall.
- R7: `ser_dout` changes only after a falling serial clock edge. It then shows the bit sampled ten rising serial clock edges earlier, or 0 if fewer bits have arrived since reset.
- R8: Each load raises `upd_stb` for exactly one system clock, and `upd_idx` carries the loaded channel index during that cycle.
- R9: A change on a serial input that is first sampled at a system clock rising edge is acted on at the third rising edge, counting that one. For a rising chip select, the new code and the strobe are visible after that third edge.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; sets all channels to midscale |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_csn | input | 1 | Active-low chip select; a rising edge loads the frame |
| ser_dout | output | 1 | Serial data out for cascading; updated after a falling serial clock edge |
| chan_codes | output | NCH*DW (32) | Channel codes; channel n is bits [n*DW +: DW] |
| upd_stb | output | 1 | One-cycle pulse when a channel is loaded |
| upd_idx | output | AW (2) | Index of the channel loaded, valid with upd_stb |

## Verification
The first patterns are full 10-bit frames to each of the four addresses with distinct data bytes, followed by an overwrite. These distinguish wrong field order, a wrong bit order and writes that land on the wrong channel or spill into other channels. A 6-bit frame and a 13-bit frame then test that the load takes the last ten bits received and keeps earlier bits when too few arrive. Serial clocks sent while chip select is high, followed by a short frame, show whether those clocks were wrongly shifted in. A reset in mid-run confirms the return to midscale. Throughout, a per-clock model checks the exact cycle in which codes, strobe and serial output change.

// File: rtl/serpot_pkg.sv
package serpot_pkg;

  // Order of the serial pins inside the synchronizer bus
  typedef struct packed {
    logic csn;
    logic sck;
    logic sdi;
  } ser_bus_t;

  localparam int SER_W = $bits(ser_bus_t);

  // Idle value of the serial pins: chip select high, clock low, data low
  localparam ser_bus_t SER_IDLE = '{csn: 1'b1, sck: 1'b0, sdi: 1'b0};

  // Midscale code: the top bit set, all others clear
  function automatic int unsigned mid_code(input int unsigned dw);
    return 32'd1 << (dw - 1);
  endfunction

endpackage

// File: rtl/serpot_sync.sv
module serpot_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/serpot_edge.sv
module serpot_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= RST_VAL;
    else        prv_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prv_q;
  assign fall_o = ~lvl_i & prv_q;

endmodule

// File: rtl/serpot_shift.sv
module serpot_shift #(
  parameter int FW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en_i,
  input  logic          bit_i,
  input  logic          out_en_i,
  output logic [FW-1:0] frame_o,
  output logic          dout_o
);

  // Newest bit enters at bit 0; the oldest leaves from the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frame_o <= '0;
    else if (shift_en_i) frame_o <= {frame_o[FW-2:0], bit_i};
  end

  // Cascade output is refreshed only after a falling serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_o <= 1'b0;
    else if (out_en_i) dout_o <= frame_o[FW-1];
  end

  // R3: the frame register moves only on an enabled shift
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(frame_o));

  // R7: the cascade output moves only after a falling serial clock
  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |=> $stable(dout_o));

endmodule

// File: rtl/serpot_regs.sv
module serpot_regs
  import serpot_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic [NCH*DW-1:0] codes_o,
  output logic              stb_o,
  output logic [AW-1:0]     idx_o
);

  localparam logic [DW-1:0] MID = DW'(mid_code(DW));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [DW-1:0] code_q;
    logic          hit;

    assign hit = load_i && (addr_i == AW'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= MID;
      else if (hit) code_q <= data_i;
    end

    assign codes_o[ch*DW +: DW] = code_q;

    // R5: a load aimed elsewhere leaves this channel alone
    p_only_addressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && idx_o != AW'(ch)) |-> $stable(codes_o[ch*DW +: DW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_o <= 1'b0;
      idx_o <= '0;
    end else begin
      stb_o <= load_i;
      if (load_i) idx_o <= addr_i;
    end
  end

  // R8: the update strobe never lasts two cycles
  p_stb_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);

endmodule

// File: rtl/serpot_bank.sv
module serpot_bank
  import serpot_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_csn,
  output logic              ser_dout,
  output logic [NCH*DW-1:0] chan_codes,
  output logic              upd_stb,
  output logic [AW-1:0]     upd_idx
);

  localparam int FW = AW + DW;

  // Field extraction from the frame register (address sits above the data)
  function automatic logic [AW-1:0] frame_addr(input logic [FW-1:0] f);
    return f[FW-1 -: AW];
  endfunction

  function automatic logic [DW-1:0] frame_data(input logic [FW-1:0] f);
    return f[DW-1:0];
  endfunction

  ser_bus_t      pins_raw, pins_syn;
  logic          sck_rise, sck_fall;
  logic          cs_prv_q, cs_rise;
  logic          shift_en;
  logic [FW-1:0] frame;

  assign pins_raw = '{csn: ser_csn, sck: ser_clk, sdi: ser_din};

  serpot_sync #(
    .W       (SER_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SER_IDLE)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .lvl_o   (pins_syn)
  );

  serpot_edge #(.RST_VAL(1'b0)) sck_edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pins_syn.sck),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prv_q <= 1'b1;
    else        cs_prv_q <= pins_syn.csn;
  end

  assign cs_rise  = pins_syn.csn & ~cs_prv_q;
  assign shift_en = sck_rise & ~pins_syn.csn;

  serpot_shift #(.FW(FW)) shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en),
    .bit_i      (pins_syn.sdi),
    .out_en_i   (sck_fall),
    .frame_o    (frame),
    .dout_o     (ser_dout)
  );

  serpot_regs #(.NCH(NCH), .DW(DW), .AW(AW)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cs_rise),
    .addr_i  (frame_addr(frame)),
    .data_i  (frame_data(frame)),
    .codes_o (chan_codes),
    .stb_o   (upd_stb),
    .idx_o   (upd_idx)
  );

  // R4: codes stay put in every cycle without a load
  p_codes_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(chan_codes));

  // R9: a detected chip select rise is followed at once by the strobe for the framed address
  p_csrise_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (upd_stb && upd_idx == $past(frame_addr(frame))));

endmodule

// File: tb/serpot_bank_tb.sv
module serpot_bank_tb_top;

  localparam int NCH = 4;
  localparam int DW  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ser_clk = 1'b0;
  logic             ser_din = 1'b0;
  logic             ser_csn = 1'b1;
  logic             ser_dout;
  logic [NCH*DW-1:0] chan_codes;
  logic             upd_stb;
  logic [1:0]       upd_idx;

  always #2.5 clk = ~clk;  // 200 MHz

  serpot_bank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .ser_csn    (ser_csn),
    .ser_dout   (ser_dout),
    .chan_codes (chan_codes),
    .upd_stb    (upd_stb),
    .upd_idx    (upd_idx)
  );

  // Reference model state
  logic [7:0] exp_code [NCH];
  logic       exp_stb = 1'b0;
  logic [1:0] exp_idx = 2'd0;
  logic       exp_dout = 1'b0;
  logic       rx_bits [$];
  bit         cmp_en = 1'b0;
  bit         done = 1'b0;
  int         checks = 0;
  int         failures = 0;
  int         stb_seen = 0;
  int         loads = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int c);
    return chan_codes[c*DW +: DW];
  endfunction

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (code_of(c) !== exp_code[c]) begin
          failures++;
          $display("FAIL R4/R9 ch%0d actual=%02h expected=%02h", c, code_of(c), exp_code[c]);
        end
      end
      checks++;
      if (upd_stb !== exp_stb) begin
        failures++;
        $display("FAIL R8 strobe actual=%0b expected=%0b", upd_stb, exp_stb);
      end
      if (exp_stb) begin
        checks++;
        if (upd_idx !== exp_idx) begin
          failures++;
          $display("FAIL R8 index actual=%0d expected=%0d", upd_idx, exp_idx);
        end
      end
      checks++;
      if (ser_dout !== exp_dout) begin
        failures++;
        $display("FAIL R7 dout actual=%0b expected=%0b", ser_dout, exp_dout);
      end
      if (upd_stb) stb_seen++;
    end
  end

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    exp_stb  = 1'b0;
    exp_dout = 1'b0;
    rx_bits.delete();
    for (int i = 0; i < 10; i++) rx_bits.push_back(1'b0);
  endtask

  task automatic do_reset();
    cmp_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    ser_csn = 1'b1;
    ser_clk = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NCH; c++) chk("R1 midscale", code_of(c), 32'h80);
    chk("R1 dout", ser_dout, 0);
    chk("R1 strobe", upd_stb, 0);
    rst_n = 1'b1;
    @(posedge clk);
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_din = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    if (!ser_csn) rx_bits.push_back(b);
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(posedge clk);
    exp_dout = rx_bits[rx_bits.size() - 10];
    @(negedge clk);
  endtask

  // Sends the low n bits of v, highest first, inside one chip select window
  task automatic frame(input logic [15:0] v, input int n);
    int sz;
    int a;
    logic [7:0] d;
    @(negedge clk);
    ser_csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    repeat (2) @(negedge clk);
    ser_csn = 1'b1;
    sz = rx_bits.size();
    a = {rx_bits[sz-10], rx_bits[sz-9]};
    for (int k = 0; k < 8; k++) d[7-k] = rx_bits[sz-8+k];
    repeat (3) @(posedge clk);  // third edge: load visible (R9)
    exp_code[a] = d;
    exp_stb = 1'b1;
    exp_idx = 2'(a);
    loads++;
    @(posedge clk);
    exp_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R2: one full frame to each address
    frame(16'b00_00111100, 10);
    frame(16'b01_10100101, 10);
    frame(16'b10_11111111, 10);
    frame(16'b11_00000000, 10);
    chk("R2 ch0", code_of(0), 32'h3C);
    chk("R2 ch1", code_of(1), 32'hA5);
    chk("R2 ch2", code_of(2), 32'hFF);
    chk("R2 ch3", code_of(3), 32'h00);
    chk("R7 cascade bit", ser_dout, 1);

    // R5: overwrite one channel, others unchanged
    frame(16'b10_00000001, 10);
    chk("R5 ch2", code_of(2), 32'h01);
    chk("R5 ch0", code_of(0), 32'h3C);
    chk("R5 ch1", code_of(1), 32'hA5);
    chk("R5 ch3", code_of(3), 32'h00);

    // R6: short frame keeps tail of previous frame -> 00 01101010
    frame(16'b101010, 6);
    chk("R6 short", code_of(0), 32'h6A);
    // R6: long frame keeps the last ten bits
    frame(16'b111_01_11001100, 13);
    chk("R6 long", code_of(1), 32'hCC);

    // R3: clocks with chip select high are not shifted in
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    frame(16'b0000, 4);
    chk("R3 ignored clocks", code_of(0), 32'hC0);

    // R1: reset in mid-run
    do_reset();
    frame(16'b11_01011010, 10);
    chk("R2 after reset", code_of(3), 32'h5A);
    chk("R1 others midscale", code_of(2), 32'h80);

    chk("R8 strobe count", stb_seen, loads);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule